// File: doc/BRIEF.md
# Prescaled Overflow Timer

This block is a free-running counter behind a four-register bus. A two-bit source field picks what advances it: nothing, every system clock, a fixed-rate tick or an external tick. The chosen ticks pass through a divider that divides by a power of two from 1 to 128, and each divider output advances the counter by one. The counter climbs to a programmable modulo value. In up mode it then wraps to zero. In up-down mode it turns around at the modulo value and falls back to zero.

Every wrap or turnaround sets a sticky overflow flag. Software clears the flag in two steps: it reads the control register while the flag is 1, then writes 0 to the flag bit. If another overflow arrives between those two accesses, the write is discarded and the flag stays set. The interrupt line is high whenever the flag is set and the interrupt enable bit is set. Writes to the counting mode, source and divider fields are dropped unless an unlock bit is set. All logic runs on one clock with a synchronous active-low reset. The fixed-rate and external ticks arrive as one-cycle enables in that clock domain.

Register map (word addresses):
- 0, control: bit 0 overflow flag, bit 1 interrupt enable, bit 2 up-down mode, bits 4:3 source, bits 7:5 divider exponent.
- 1, counter.
- 2, modulo.
- 3, unlock in bit 0.

Top module: `ovf_timer`

## Requirements
- R1: After reset every register reads 0 (control, counter, modulo, unlock), and irq is 0.
- R2: The source field (control bits 4:3) selects the count source. With source 00 the counter does not move. With source 01 it advances on every clock cycle.
- R3: With source 10 the counter advances only on fix_tick pulses, and with source 11 only on ext_tick pulses. Pulses on the other tick input are ignored.
- R4: The divider exponent p (control bits 7:5) makes the counter advance once per 2^p source ticks. Counting from a counter write, the first advance comes on the 2^p-th tick. A new p applies from the cycle after the write.
- R5: In up mode (control bit 2 = 0), an advance at the modulo value loads 0 and sets the overflow flag.
- R6: In up-down mode (control bit 2 = 1), the counter runs 0 up to the modulo value and back down to 0. The flag is set when the counter turns around at the modulo value.
- R7: Reading control while the flag is 1, then writing control with bit 0 = 0, clears the flag.
- R8: A control write that does not follow such a read leaves the flag unchanged.
- R9: If an overflow occurs after the arming read and up to and including the clearing write, the flag stays 1.
- R10: irq is 1 exactly when the flag and the interrupt enable (control bit 1) are both 1.
- R11: While unlock (address 3, bit 0) is 0, control writes leave the mode, source and divider fields unchanged. The interrupt enable bit is still written.
- R12: Any write to the counter register sets the counter to 0, whatever the data, and restarts the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fix_tick | input | 1 | Fixed-rate count enable, one cycle wide |
| ext_tick | input | 1 | External count enable, one cycle wide |
| bus_addr | input | ADDR_W | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (arms the flag clear) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| irq | output | 1 | Overflow interrupt request |

## Verification
The assertions check these rules on every cycle:
- A stopped source freezes the counter.
- An up-mode overflow leaves zero behind.
- An up-down overflow turns the counter downward.
- Every overflow leaves the flag set.
- An unarmed control write never clears the flag.
- Locked fields hold through control writes.
- A counter write yields zero.

Other behaviour depends on long sequences and on arithmetic, so only the bench scenarios show it. That covers:
- the exact counter value after many divided ticks in both modes;
- that the read-then-write handshake really clears the flag;
- that an overflow landing inside the handshake cancels the clear;
- that the unused tick input is ignored.

// File: rtl/ovf_timer_pkg.sv
package ovf_timer_pkg;

  typedef enum logic [1:0] {
    SRC_OFF = 2'b00,
    SRC_SYS = 2'b01,
    SRC_FIX = 2'b10,
    SRC_EXT = 2'b11
  } src_e;

  // register word addresses
  localparam int A_CTRL   = 0;
  localparam int A_COUNT  = 1;
  localparam int A_MODULO = 2;
  localparam int A_UNLOCK = 3;

  // control field positions
  localparam int B_FLAG  = 0;
  localparam int B_IE    = 1;
  localparam int B_UD    = 2;
  localparam int B_SRC   = 3;
  localparam int B_PS    = 5;
  localparam int CTRL_W  = 8;

endpackage

// File: rtl/ovf_timer_presc.sv
module ovf_timer_presc
  import ovf_timer_pkg::*;
#(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  src_e            src,
  input  logic [PS_W-1:0] ps,
  input  logic            fix_tick,
  input  logic            ext_tick,
  input  logic            restart,
  output logic            src_tick,
  output logic            cnt_en
);
  localparam int PRE_W = (1 << PS_W) - 1;

  // low bits that must all be set before the divider releases a tick
  function automatic logic [PRE_W-1:0] div_mask(input logic [PS_W-1:0] e);
    return (PRE_W'(1) << e) - PRE_W'(1);
  endfunction

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  always_comb begin
    unique case (src)
      SRC_SYS: src_tick = 1'b1;
      SRC_FIX: src_tick = fix_tick;
      SRC_EXT: src_tick = ext_tick;
      default: src_tick = 1'b0;
    endcase
  end

  assign mask   = div_mask(ps);
  assign cnt_en = src_tick && ((pre_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) pre_q <= '0;
    else if (src_tick)     pre_q <= pre_q + PRE_W'(1);
  end

endmodule

// File: rtl/ovf_timer_core.sv
module ovf_timer_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             updown,
  input  logic [CNT_W-1:0] modulo,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt,
  output logic             dir_down,
  output logic             ovf_evt
);
  logic [CNT_W-1:0] cnt_d;
  logic             dir_d;
  logic             at_top;

  // at or above the limit (also catches a modulo lowered below the count)
  function automatic logic reached(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] m);
    return c >= m;
  endfunction

  assign at_top  = reached(cnt, modulo);
  assign ovf_evt = cnt_en && !restart && at_top && (!updown || !dir_down);

  always_comb begin
    cnt_d = cnt;
    dir_d = dir_down;
    if (restart) begin
      cnt_d = '0;
      dir_d = 1'b0;
    end else if (!updown) begin
      dir_d = 1'b0;
      if (cnt_en) cnt_d = at_top ? '0 : cnt + CNT_W'(1);
    end else if (cnt_en) begin
      if (!dir_down) begin
        if (!at_top)               cnt_d = cnt + CNT_W'(1);
        else if (modulo != '0) begin
          cnt_d = cnt - CNT_W'(1);
          dir_d = 1'b1;
        end
      end else if (cnt == '0) begin
        dir_d = 1'b0;
        cnt_d = (modulo == '0) ? '0 : CNT_W'(1);
      end else begin
        cnt_d = cnt - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      dir_down <= 1'b0;
    end else begin
      cnt      <= cnt_d;
      dir_down <= dir_d;
    end
  end

endmodule

// File: rtl/ovf_timer_regs.sv
module ovf_timer_regs
  import ovf_timer_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int PS_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              ovf_evt,
  output logic              flag,
  output logic              ie,
  output logic              updown,
  output src_e              src,
  output logic [PS_W-1:0]   ps,
  output logic [CNT_W-1:0]  modulo,
  output logic              unlock,
  output logic              armed,
  output logic              ctrl_wr,
  output logic              cnt_wr
);
  logic ctrl_rd;
  logic clear_ok;
  logic mod_wr;
  logic unl_wr;

  assign ctrl_wr  = bus_wr && (bus_addr == ADDR_W'(A_CTRL));
  assign ctrl_rd  = bus_rd && (bus_addr == ADDR_W'(A_CTRL));
  assign cnt_wr   = bus_wr && (bus_addr == ADDR_W'(A_COUNT));
  assign mod_wr   = bus_wr && (bus_addr == ADDR_W'(A_MODULO));
  assign unl_wr   = bus_wr && (bus_addr == ADDR_W'(A_UNLOCK));
  assign clear_ok = ctrl_wr && armed && !bus_wdata[B_FLAG] && !ovf_evt;

  // flag and the arming record of the two-step clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (ovf_evt)       flag <= 1'b1;
      else if (clear_ok) flag <= 1'b0;
      if (ovf_evt || ctrl_wr)   armed <= 1'b0;
      else if (ctrl_rd && flag) armed <= 1'b1;
    end
  end

  // control fields; mode, source and divider honour the unlock bit
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie     <= 1'b0;
      updown <= 1'b0;
      src    <= SRC_OFF;
      ps     <= '0;
      modulo <= '0;
      unlock <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        ie <= bus_wdata[B_IE];
        if (unlock) begin
          updown <= bus_wdata[B_UD];
          src    <= src_e'(bus_wdata[B_SRC +: 2]);
          ps     <= bus_wdata[B_PS +: PS_W];
        end
      end
      if (mod_wr) modulo <= bus_wdata[CNT_W-1:0];
      if (unl_wr) unlock <= bus_wdata[0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(A_CTRL):   bus_rdata = DATA_W'({ps, src, updown, ie, flag});
      ADDR_W'(A_COUNT):  bus_rdata = DATA_W'(cnt);
      ADDR_W'(A_MODULO): bus_rdata = DATA_W'(modulo);
      default:           bus_rdata = DATA_W'(unlock);
    endcase
  end

endmodule

// File: rtl/ovf_timer.sv
module ovf_timer
  import ovf_timer_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16,
  parameter int PS_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fix_tick,
  input  logic              ext_tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  // named internal events, brought out for the checker
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] modulo;
  logic [PS_W-1:0]  ps;
  src_e             src;
  logic flag, ie, updown, unlock, armed;
  logic ctrl_wr, cnt_wr, src_tick, cnt_en, ovf_evt, dir_down;

  ovf_timer_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .PS_W(PS_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt(cnt), .ovf_evt(ovf_evt),
    .flag(flag), .ie(ie), .updown(updown), .src(src), .ps(ps),
    .modulo(modulo), .unlock(unlock), .armed(armed),
    .ctrl_wr(ctrl_wr), .cnt_wr(cnt_wr)
  );

  ovf_timer_presc #(.PS_W(PS_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .src(src), .ps(ps),
    .fix_tick(fix_tick), .ext_tick(ext_tick), .restart(cnt_wr),
    .src_tick(src_tick), .cnt_en(cnt_en)
  );

  ovf_timer_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .updown(updown),
    .modulo(modulo), .restart(cnt_wr),
    .cnt(cnt), .dir_down(dir_down), .ovf_evt(ovf_evt)
  );

  assign irq = flag & ie;

endmodule

// File: rtl/ovf_timer_chk.sv
module ovf_timer_chk #(
  parameter int CNT_W = 16,
  parameter int PS_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] modulo,
  input logic [1:0]       src,
  input logic [PS_W-1:0]  ps,
  input logic             flag,
  input logic             ie,
  input logic             irq,
  input logic             updown,
  input logic             unlock,
  input logic             armed,
  input logic             dir_down,
  input logic             ovf_evt,
  input logic             cnt_en,
  input logic             ctrl_wr,
  input logic             cnt_wr
);
  a_r2_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (src == 2'b00 && !cnt_wr) |=> $stable(cnt));

  a_r2_off_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (src == 2'b00) |-> !cnt_en);

  a_r5_up_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && !updown) |=> (cnt == '0));

  a_r6_turns_down: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && updown && modulo != '0) |=> dir_down);

  a_r9_ovf_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> flag);

  a_r8_unarmed_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !armed && flag) |=> flag);

  a_r10_irq_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flag && ie));

  a_r11_locked_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !unlock) |=> ($stable(src) && $stable(ps) && $stable(updown)));

  a_r12_write_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt == '0));

endmodule

bind ovf_timer ovf_timer_chk #(.CNT_W(CNT_W), .PS_W(PS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt), .modulo(modulo), .src(src), .ps(ps),
  .flag(flag), .ie(ie), .irq(irq), .updown(updown), .unlock(unlock),
  .armed(armed), .dir_down(dir_down), .ovf_evt(ovf_evt), .cnt_en(cnt_en),
  .ctrl_wr(ctrl_wr), .cnt_wr(cnt_wr)
);

// File: tb/test_ovf_timer.sv
`timescale 1ns/1ps
module test_ovf_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fix_tick = 1'b0, ext_tick = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  ovf_timer i_ovf_timer (
    .clk(clk), .rst_n(rst_n), .fix_tick(fix_tick), .ext_tick(ext_tick),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // vector: {updown, exponent, modulo[7:0], cycles[9:0]}
  localparam logic [21:0] VECS [0:7] = '{
    {1'b0, 3'd0, 8'd9,  10'd12},
    {1'b0, 3'd1, 8'd5,  10'd30},
    {1'b0, 3'd3, 8'd7,  10'd100},
    {1'b1, 3'd0, 8'd6,  10'd20},
    {1'b1, 3'd2, 8'd4,  10'd50},
    {1'b0, 3'd7, 8'd3,  10'd600},
    {1'b1, 3'd1, 8'd10, 10'd15},
    {1'b0, 3'd0, 8'd1,  10'd5}
  };

  function automatic logic [15:0] ctrl_word(int e, int s, int ud, int en);
    return 16'((e << 5) | (s << 3) | (ud << 2) | (en << 1));
  endfunction

  // expected count: position within one period of advances
  function automatic int model_cnt(int ud, int e, int m, int n);
    int adv = n / (1 << e);
    if (!ud) return adv % (m + 1);
    if (m == 0) return 0;
    begin
      int k = adv % (2 * m);
      return (k <= m) ? k : 2 * m - k;
    end
  endfunction

  function automatic int model_flag(int e, int m, int n);
    return ((n / (1 << e)) > m) ? 1 : 0;
  endfunction

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(int a, logic [15:0] d);
    bus_addr = 2'(a); bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(int a, output int v);
    bus_addr = 2'(a); bus_rd = 1'b1;
    #1 v = int'(bus_rdata);
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic pulse(logic sel_ext);
    if (sel_ext) ext_tick = 1'b1; else fix_tick = 1'b1;
    @(negedge clk);
    ext_tick = 1'b0; fix_tick = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v;
    @(negedge clk);
    do_reset();

    // R1: reset state
    check("R1 irq", int'(irq), 0);
    for (int a = 0; a < 4; a++) begin
      rd(a, v);
      check("R1 reg", v, 0);
    end

    // R4 R5 R6: vector table with the system clock as source
    for (int i = 0; i < 8; i++) begin
      int ud = int'(VECS[i][21]);
      int e  = int'(VECS[i][20:18]);
      int m  = int'(VECS[i][17:10]);
      int n  = int'(VECS[i][9:0]);
      do_reset();
      wr(3, 16'h1);
      wr(2, 16'(m));
      wr(0, ctrl_word(e, 1, ud, 0));
      wr(1, 16'hFFFF);
      repeat (n) @(negedge clk);
      rd(1, v);
      check(ud ? "R6 count" : "R4 R5 count", v, model_cnt(ud, e, m, n));
      rd(0, v);
      check(ud ? "R6 flag" : "R5 flag", v & 1, model_flag(e, m, n));
    end

    // R2: source off holds the counter
    do_reset();
    wr(3, 16'h1);
    wr(2, 16'd50);
    wr(0, ctrl_word(0, 0, 0, 0));
    repeat (10) @(negedge clk);
    rd(1, v);
    check("R2 off", v, 0);

    // R3: fixed-rate and external tick selection
    wr(0, ctrl_word(0, 2, 0, 0));
    wr(1, 16'h0);
    repeat (3) pulse(1'b0);
    repeat (2) pulse(1'b1);
    rd(1, v);
    check("R3 fixed", v, 3);
    wr(0, ctrl_word(0, 3, 0, 0));
    wr(1, 16'h0);
    repeat (4) pulse(1'b1);
    repeat (2) pulse(1'b0);
    rd(1, v);
    check("R3 external", v, 4);

    // R12: counter write mid-run
    wr(0, ctrl_word(0, 1, 0, 0));
    repeat (7) @(negedge clk);
    wr(1, 16'hABCD);
    rd(1, v);
    check("R12 zeroed", v, 0);

    // R8 then R7: stop counter with an unarmed write, then clear properly
    do_reset();
    wr(3, 16'h1);
    wr(2, 16'd1);
    wr(0, ctrl_word(0, 1, 0, 1));
    wr(1, 16'h0);
    repeat (5) @(negedge clk);
    check("R10 irq set", int'(irq), 1);
    wr(0, ctrl_word(0, 0, 0, 1));
    check("R8 unarmed write", int'(irq), 1);
    rd(0, v);
    check("R8 flag readback", v & 1, 1);
    wr(0, ctrl_word(0, 0, 0, 1));
    check("R7 cleared irq", int'(irq), 0);
    rd(0, v);
    check("R7 cleared flag", v & 1, 0);

    // R9: overflow lands between read and write
    wr(0, ctrl_word(0, 1, 0, 1));
    wr(1, 16'h0);
    repeat (4) @(negedge clk);
    rd(0, v);
    @(negedge clk);
    wr(0, ctrl_word(0, 1, 0, 1));
    check("R9 clear cancelled", int'(irq), 1);

    // R10: enable off masks the request while the flag holds
    wr(0, ctrl_word(0, 0, 0, 0));
    check("R10 irq masked", int'(irq), 0);
    rd(0, v);
    check("R10 flag kept", v & 1, 1);

    // R11: locked fields ignore writes, enable still writes
    do_reset();
    wr(0, ctrl_word(5, 2, 1, 1));
    rd(0, v);
    check("R11 locked", v, 2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule